// File: doc/BRIEF.md
# Real-Time Clock Calendar Counter

This block keeps the time of day and the calendar date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-hertz tick from outside starts an update sequence that advances the time by one second, carrying through minutes, hours, days, months and years. Month lengths and leap years (every year divisible by four within 00-99) set where the day of month wraps.

Every value is held in the encoding the host selects, either packed BCD or plain binary. The hour uses either 24-hour or 12-hour form. In 12-hour form, bit 7 of the hour byte marks PM. Three alarm bytes for second, minute and hour are compared with the time once after each update. When all three match, a one-cycle pulse is raised. A byte-wide register port lets the host read and write the time, the alarms and the control bits.

Top module: `rtc_calendar`

## Requirements
- R1: After a synchronous reset the time reads 00:00:00 (hour byte 00h), day of week 01h, day of month 01h, month 01h, year 00h, all alarm bytes 00h, control 82h and status 00h.
- R2: Seconds and minutes count 0 to 59. In BCD the byte 59h wraps to 00h, and in binary 3Bh wraps to 00h. A seconds wrap advances the minutes, and a minutes wrap advances the hour.
- R3: In 24-hour mode the hour counts 0 to 23 (BCD 23h or binary 17h wraps to 00h), and that wrap advances the date.
- R4: In 12-hour mode the hour byte holds 1 to 12, with bit 7 set for PM. 11 AM goes to 12 PM (BCD 11h to 92h), 12 PM goes to 1 PM (92h to 81h), 11 PM goes to 12 AM (91h to 12h), and 12 AM goes to 1 AM (12h to 01h). Only the change into 12 AM advances the date.
- R5: Each date advance moves the day of week on, with 7 wrapping to 1. The day of month wraps to 1 after the last day of the month: 28 or 29 for month 2 (29 when the year is divisible by 4), 30 for months 4, 6, 9 and 11, and 31 otherwise. That wrap advances the month. Month 12 wraps to 1 and advances the year, and year 99 wraps to 00.
- R6: Register map by address: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 8 second alarm, 9 minute alarm, 10 hour alarm, 12 control, 13 status; all other addresses read 00h. Control bit 7 enables updates, bit 2 selects binary (1) or BCD (0), and bit 1 selects 24-hour (1) or 12-hour (0). The other control bits read 0.
- R7: While control bit 7 is 0, ticks are ignored. The time does not change and the status stays 00h.
- R8: When the tick is sampled high at a clock edge while updates are enabled and no update is running, status bit 7 reads 1 for exactly the next cycle. The advanced time is visible after the following edge. A tick sampled while status bit 7 is 1 is ignored. Writes to the status register have no effect.
- R9: One cycle after the time advances, the alarm pulse goes high for exactly one cycle. This happens only when the second, minute and hour alarm bytes each equal their time bytes.
- R10: Bit 7 of the seconds register is read-only and always reads 0.
- R11: A host write takes effect at the next clock edge. A write in the same cycle as the time advance wins for the register it targets, while the other time registers still advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-hertz update request, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| alarm_pulse | output | 1 | One-cycle alarm match pulse |

## Verification
A wrong carry decision or a wrong encoding step inside the advance logic shows up on the register port at the first read after the edge that commits the update. So a reference model that reads the port every cycle catches it two cycles after the tick. A wrong alarm compare, or wrong sequencing of the compare, appears on `alarm_pulse` in the third cycle after the tick. The test set targets the boundaries where most wrong states would hide: the 12-hour meridian changes, month ends with and without a leap year, the year wrap, and a host write that collides with a commit.

// File: rtl/rtc_pkg.sv
// Package rtc_pkg
// Shared register addresses, the time record and the pure helper
// functions that convert between the host encoding (BCD or binary) and
// plain binary values. Assumes field values of at most 99.
package rtc_pkg;

    localparam int BYTE_W = 8;

    // register addresses seen by the host
    localparam int A_SEC   = 0;
    localparam int A_MIN   = 1;
    localparam int A_HOUR  = 2;
    localparam int A_DOW   = 3;
    localparam int A_DOM   = 4;
    localparam int A_MON   = 5;
    localparam int A_YEAR  = 6;
    localparam int A_ASEC  = 8;
    localparam int A_AMIN  = 9;
    localparam int A_AHOUR = 10;
    localparam int A_CTRL  = 12;
    localparam int A_STAT  = 13;

    // number of alarm fields compared against the time
    localparam int N_ALARM = 3;

    // control reset value: updates on, BCD, 24-hour
    localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h82;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] dom;
        logic [BYTE_W-1:0] mon;
        logic [BYTE_W-1:0] year;
    } rtc_time_t;

    localparam rtc_time_t TIME_RESET = '{
        sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h01,
        dom: 8'h01, mon: 8'h01, year: 8'h00
    };

    // host encoding to plain binary
    function automatic logic [BYTE_W-1:0] enc_to_bin(
        input logic [BYTE_W-1:0] v, input logic bin_mode);
        if (bin_mode) return v;
        return ({4'b0000, v[7:4]} * 8'd10) + {4'b0000, v[3:0]};
    endfunction

    // plain binary to host encoding
    function automatic logic [BYTE_W-1:0] bin_to_enc(
        input logic [BYTE_W-1:0] b, input logic bin_mode);
        logic [BYTE_W-1:0] tens;
        logic [BYTE_W-1:0] ones;
        if (bin_mode) return b;
        tens = b / 8'd10;
        ones = b % 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    // last day of a month given binary month and year
    function automatic logic [BYTE_W-1:0] month_len(
        input logic [BYTE_W-1:0] mon, input logic [BYTE_W-1:0] year);
        case (mon)
            8'd2:                     return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
            default:                  return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_update_seq.sv
// Module rtc_update_seq
// Turns a one-cycle tick into a two-step update: one cycle marked as
// update-in-progress, followed by the commit edge, followed by one cycle
// in which the alarm compare is armed. Assumes ticks are far apart;
// a tick seen while an update is in progress is dropped.
module rtc_update_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic upd_en,
    output logic uip,
    output logic chk
);

    logic uip_q;
    logic chk_q;

    // start an update when enabled and idle
    always_ff @(posedge clk) begin
        if (!rst_n) uip_q <= 1'b0;
        else        uip_q <= tick && upd_en && !uip_q;
    end

    // arm the alarm compare the cycle after the commit edge
    always_ff @(posedge clk) begin
        if (!rst_n) chk_q <= 1'b0;
        else        chk_q <= uip_q;
    end

    assign uip = uip_q;
    assign chk = chk_q;

endmodule

// File: rtl/rtc_time_advance.sv
// Module rtc_time_advance
// Purely combinational: given the current time in host encoding and the
// two mode bits, produces the time one second later in the same
// encoding. Assumes fields hold in-range values; out-of-range values
// are forced to wrap at the next boundary test.
module rtc_time_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      bin_mode,
    input  logic      h24_mode,
    output rtc_time_t nxt
);

    logic [BYTE_W-1:0] s_b, m_b, h_b, d_b, mo_b, y_b;
    logic [BYTE_W-1:0] s_n, m_n, h_n, d_n, mo_n, y_n, w_n;
    logic              pm_c, pm_n;
    logic              min_cy, hr_cy, day_cy, mon_cy, yr_cy;
    logic [BYTE_W-1:0] h_enc;

    // decode every field to plain binary
    always_comb begin
        s_b  = enc_to_bin(cur.sec, bin_mode);
        m_b  = enc_to_bin(cur.min, bin_mode);
        pm_c = cur.hour[7] && !h24_mode;
        h_b  = h24_mode ? enc_to_bin(cur.hour, bin_mode)
                        : enc_to_bin({1'b0, cur.hour[6:0]}, bin_mode);
        d_b  = enc_to_bin(cur.dom, bin_mode);
        mo_b = enc_to_bin(cur.mon, bin_mode);
        y_b  = enc_to_bin(cur.year, bin_mode);
    end

    // seconds and minutes with their carries
    always_comb begin
        min_cy = (s_b >= 8'd59);
        s_n    = min_cy ? 8'd0 : s_b + 8'd1;
        hr_cy  = min_cy && (m_b >= 8'd59);
        m_n    = !min_cy ? m_b : (hr_cy ? 8'd0 : m_b + 8'd1);
    end

    // hour step in the selected hour format
    always_comb begin
        h_n    = h_b;
        pm_n   = pm_c;
        day_cy = 1'b0;
        if (hr_cy) begin
            if (h24_mode) begin
                day_cy = (h_b >= 8'd23);
                h_n    = day_cy ? 8'd0 : h_b + 8'd1;
            end else if (h_b == 8'd11) begin
                h_n    = 8'd12;
                pm_n   = !pm_c;
                day_cy = pm_c;
            end else if (h_b >= 8'd12) begin
                h_n    = 8'd1;
            end else begin
                h_n    = h_b + 8'd1;
            end
        end
    end

    // date chain: weekday, day of month, month, year
    always_comb begin
        w_n    = cur.dow;
        d_n    = d_b;
        mo_n   = mo_b;
        y_n    = y_b;
        mon_cy = 1'b0;
        yr_cy  = 1'b0;
        if (day_cy) begin
            w_n    = (cur.dow >= 8'd7) ? 8'd1 : cur.dow + 8'd1;
            mon_cy = (d_b >= month_len(mo_b, y_b));
            d_n    = mon_cy ? 8'd1 : d_b + 8'd1;
        end
        if (mon_cy) begin
            yr_cy = (mo_b >= 8'd12);
            mo_n  = yr_cy ? 8'd1 : mo_b + 8'd1;
        end
        if (yr_cy) begin
            y_n = (y_b >= 8'd99) ? 8'd0 : y_b + 8'd1;
        end
    end

    // re-encode to the host format
    always_comb begin
        h_enc    = bin_to_enc(h_n, bin_mode);
        nxt.sec  = bin_to_enc(s_n, bin_mode);
        nxt.min  = bin_to_enc(m_n, bin_mode);
        nxt.hour = h24_mode ? h_enc : {pm_n, h_enc[6:0]};
        nxt.dow  = w_n;
        nxt.dom  = bin_to_enc(d_n, bin_mode);
        nxt.mon  = bin_to_enc(mo_n, bin_mode);
        nxt.year = bin_to_enc(y_n, bin_mode);
    end

endmodule

// File: rtl/rtc_alarm_cmp.sv
// Module rtc_alarm_cmp
// Compares each alarm byte with its time byte and registers a one-cycle
// pulse when all of them agree in a cycle where the compare is armed.
// Assumes the arm input is itself at most one cycle wide.
module rtc_alarm_cmp
    import rtc_pkg::*;
#(
    parameter int N_FIELDS = N_ALARM
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           arm,
    input  logic [N_FIELDS-1:0][BYTE_W-1:0] cur_f,
    input  logic [N_FIELDS-1:0][BYTE_W-1:0] alm_f,
    output logic                           pulse
);

    logic [N_FIELDS-1:0] eq;

    // one equality test per field
    for (genvar g = 0; g < N_FIELDS; g++) begin : g_eq
        assign eq[g] = (cur_f[g] == alm_f[g]);
    end

    logic pulse_q;

    // register the armed match as the alarm pulse
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= arm && (&eq);
    end

    assign pulse = pulse_q;

endmodule

// File: rtl/rtc_calendar.sv
// Module rtc_calendar (top)
// Holds the time, alarm and control registers, serves host reads and
// writes, and applies the advanced time on the commit edge of each
// update. Assumes the tick is synchronous to clk and one cycle wide.
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              alarm_pulse
);

    localparam logic [ADDR_W-1:0] L_SEC   = ADDR_W'(A_SEC);
    localparam logic [ADDR_W-1:0] L_MIN   = ADDR_W'(A_MIN);
    localparam logic [ADDR_W-1:0] L_HOUR  = ADDR_W'(A_HOUR);
    localparam logic [ADDR_W-1:0] L_DOW   = ADDR_W'(A_DOW);
    localparam logic [ADDR_W-1:0] L_DOM   = ADDR_W'(A_DOM);
    localparam logic [ADDR_W-1:0] L_MON   = ADDR_W'(A_MON);
    localparam logic [ADDR_W-1:0] L_YEAR  = ADDR_W'(A_YEAR);
    localparam logic [ADDR_W-1:0] L_ASEC  = ADDR_W'(A_ASEC);
    localparam logic [ADDR_W-1:0] L_AMIN  = ADDR_W'(A_AMIN);
    localparam logic [ADDR_W-1:0] L_AHOUR = ADDR_W'(A_AHOUR);
    localparam logic [ADDR_W-1:0] L_CTRL  = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] L_STAT  = ADDR_W'(A_STAT);

    rtc_time_t         tm_q, tm_nxt;
    logic [BYTE_W-1:0] asec_q, amin_q, ahour_q;
    logic              upd_en_q, bin_q, h24_q;
    logic              uip, chk;
    logic              wr_sec, wr_hour, wr_min;

    assign wr_sec  = wr_en && (addr == L_SEC);
    assign wr_min  = wr_en && (addr == L_MIN);
    assign wr_hour = wr_en && (addr == L_HOUR);

    rtc_update_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1hz),
        .upd_en (upd_en_q),
        .uip    (uip),
        .chk    (chk)
    );

    rtc_time_advance u_adv (
        .cur      (tm_q),
        .bin_mode (bin_q),
        .h24_mode (h24_q),
        .nxt      (tm_nxt)
    );

    rtc_alarm_cmp #(.N_FIELDS(N_ALARM)) u_alm (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (chk),
        .cur_f ({tm_q.hour, tm_q.min, tm_q.sec}),
        .alm_f ({ahour_q, amin_q, asec_q}),
        .pulse (alarm_pulse)
    );

    // time registers: commit the advance, then let a host write win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q <= TIME_RESET;
        end else begin
            if (uip) tm_q <= tm_nxt;
            if (wr_en) begin
                case (addr)
                    L_SEC:   tm_q.sec  <= {1'b0, wdata[6:0]};
                    L_MIN:   tm_q.min  <= wdata;
                    L_HOUR:  tm_q.hour <= wdata;
                    L_DOW:   tm_q.dow  <= wdata;
                    L_DOM:   tm_q.dom  <= wdata;
                    L_MON:   tm_q.mon  <= wdata;
                    L_YEAR:  tm_q.year <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // alarm and control registers: host writes only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asec_q   <= '0;
            amin_q   <= '0;
            ahour_q  <= '0;
            upd_en_q <= CTRL_RESET[7];
            bin_q    <= CTRL_RESET[2];
            h24_q    <= CTRL_RESET[1];
        end else if (wr_en) begin
            case (addr)
                L_ASEC:  asec_q  <= wdata;
                L_AMIN:  amin_q  <= wdata;
                L_AHOUR: ahour_q <= wdata;
                L_CTRL: begin
                    upd_en_q <= wdata[7];
                    bin_q    <= wdata[2];
                    h24_q    <= wdata[1];
                end
                default: ;
            endcase
        end
    end

    // read multiplexer
    always_comb begin
        case (addr)
            L_SEC:   rdata = tm_q.sec;
            L_MIN:   rdata = tm_q.min;
            L_HOUR:  rdata = tm_q.hour;
            L_DOW:   rdata = tm_q.dow;
            L_DOM:   rdata = tm_q.dom;
            L_MON:   rdata = tm_q.mon;
            L_YEAR:  rdata = tm_q.year;
            L_ASEC:  rdata = asec_q;
            L_AMIN:  rdata = amin_q;
            L_AHOUR: rdata = ahour_q;
            L_CTRL:  rdata = {upd_en_q, 4'b0000, bin_q, h24_q, 1'b0};
            L_STAT:  rdata = {uip, 7'b0000000};
            default: rdata = '0;
        endcase
    end

    // time stays put unless an update commits or the host writes
    p_time_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip && !wr_en) |=> $stable(tm_q));

    // binary seconds wrap from 59 to 0 and carry into minutes
    p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (uip && bin_q && !wr_sec && !wr_min && tm_q.sec == 8'h3B && tm_q.min == 8'h10)
        |=> (tm_q.sec == 8'h00 && tm_q.min == 8'h11));

    // BCD 24-hour midnight wrap
    p_hour_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (uip && !bin_q && h24_q && !wr_hour && tm_q.hour == 8'h23 &&
         tm_q.min == 8'h59 && tm_q.sec == 8'h59)
        |=> (tm_q.hour == 8'h00));

    // alarm pulse is exactly one cycle wide
    p_alarm_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse |=> !alarm_pulse);

    // alarm pulse only follows a commit by one cycle
    p_alarm_after_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse |-> $past(uip, 2));

    // disabled updates never start
    p_no_update_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en_q && !uip) |=> !uip);

endmodule

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
    import rtc_pkg::*;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       alarm_pulse;

    int  n_chk = 0;
    int  n_err = 0;
    int  n_alarm = 0;
    bit  cmp_on = 0;
    bit  done = 0;

    // reference model state (host-encoded bytes)
    int m_s, m_mi, m_h, m_dw, m_dm, m_mo, m_y, m_as, m_am, m_ah, m_ctl;
    bit m_uip, m_chk, m_alm;

    always #(CLK_P/2) clk = ~clk;

    rtc_calendar #(.ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .alarm_pulse(alarm_pulse)
    );

    function automatic int dec(int v, bit b);
        return b ? v : ((v >> 4) * 10 + (v & 15));
    endfunction

    function automatic int enc(int v, bit b);
        return b ? v : (((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic m_advance(int ctl);
        bit b = ((ctl >> 2) & 1) == 1;
        bit t24 = ((ctl >> 1) & 1) == 1;
        int s = dec(m_s, b), mi = dec(m_mi, b), h24, hv, d, mo, y;
        bit day = 0;
        if (t24) h24 = dec(m_h, b);
        else begin
            hv = dec(m_h & 127, b);
            h24 = (hv % 12) + (((m_h >> 7) & 1) == 1 ? 12 : 0);
        end
        s++;
        if (s == 60) begin
            s = 0; mi++;
            if (mi == 60) begin
                mi = 0; h24 = (h24 + 1) % 24; day = (h24 == 0);
            end
        end
        m_s = enc(s, b); m_mi = enc(mi, b);
        if (t24) m_h = enc(h24, b);
        else m_h = ((h24 >= 12) ? 128 : 0) | enc((h24 % 12 == 0) ? 12 : h24 % 12, b);
        if (day) begin
            m_dw = (m_dw == 7) ? 1 : m_dw + 1;
            d = dec(m_dm, b); mo = dec(m_mo, b); y = dec(m_y, b);
            d++;
            if (d > dim(mo, y)) begin
                d = 1; mo++;
                if (mo > 12) begin mo = 1; y = (y + 1) % 100; end
            end
            m_dm = enc(d, b); m_mo = enc(mo, b); m_y = enc(y, b);
        end
    endtask

    function automatic int m_read(int a);
        case (a)
            A_SEC: return m_s;   A_MIN: return m_mi;  A_HOUR: return m_h;
            A_DOW: return m_dw;  A_DOM: return m_dm;  A_MON: return m_mo;
            A_YEAR: return m_y;  A_ASEC: return m_as; A_AMIN: return m_am;
            A_AHOUR: return m_ah; A_CTRL: return m_ctl;
            A_STAT: return m_uip ? 8'h80 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(int a);
        case (a)
            A_SEC, A_MIN: return "R2";
            A_HOUR: return (((m_ctl >> 1) & 1) == 1) ? "R3" : "R4";
            A_DOW, A_DOM, A_MON, A_YEAR: return "R5";
            A_CTRL: return "R6";
            A_STAT: return "R8";
            default: return "R11";
        endcase
    endfunction

    // model step on each edge, from the inputs held across it
    always @(posedge clk) begin
        bit na, nu;
        int oc;
        if (!rst_n) begin
            m_s = 0; m_mi = 0; m_h = 0; m_dw = 1; m_dm = 1; m_mo = 1; m_y = 0;
            m_as = 0; m_am = 0; m_ah = 0; m_ctl = 'h82;
            m_uip = 0; m_chk = 0; m_alm = 0;
        end else begin
            oc = m_ctl;
            na = m_chk && m_as == m_s && m_am == m_mi && m_ah == m_h;
            if (m_uip) m_advance(oc);
            if (wr_en) begin
                case (int'(addr))
                    A_SEC: m_s = wdata & 127;  A_MIN: m_mi = wdata;
                    A_HOUR: m_h = wdata;       A_DOW: m_dw = wdata;
                    A_DOM: m_dm = wdata;       A_MON: m_mo = wdata;
                    A_YEAR: m_y = wdata;       A_ASEC: m_as = wdata;
                    A_AMIN: m_am = wdata;      A_AHOUR: m_ah = wdata;
                    A_CTRL: m_ctl = wdata & 'h86;
                    default: ;
                endcase
            end
            nu = tick_1hz && ((oc >> 7) & 1) == 1 && !m_uip;
            m_chk = m_uip; m_uip = nu; m_alm = na;
        end
    end

    // compare the port against the model every cycle
    always @(negedge clk) begin
        if (cmp_on) begin
            n_chk++;
            if (rdata !== 8'(m_read(int'(addr)))) begin
                n_err++;
                $display("FAIL %s model addr %0d: got %02h exp %02h",
                         req_of(int'(addr)), addr, rdata, 8'(m_read(int'(addr))));
            end
            n_chk++;
            if (alarm_pulse !== m_alm) begin
                n_err++;
                $display("FAIL R9 alarm_pulse: got %0b exp %0b", alarm_pulse, m_alm);
            end
            if (alarm_pulse === 1'b1) n_alarm++;
        end
    end

    task automatic chk(int got, int exp, string tag);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %02h exp %02h", tag, got, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(posedge clk); #1 wr_en = 1; addr = 4'(a); wdata = 8'(d);
        @(posedge clk); #1 wr_en = 0;
    endtask

    task automatic rd(int a, int e, string tag);
        @(posedge clk); #1 addr = 4'(a);
        @(negedge clk); chk(int'(rdata), e, tag);
    endtask

    task automatic tick1();
        @(posedge clk); #1 tick_1hz = 1;
        @(posedge clk); #1 tick_1hz = 0;
        repeat (3) @(posedge clk);
    endtask

    task automatic set_t(int h, int m, int s);
        wr(A_HOUR, h); wr(A_MIN, m); wr(A_SEC, s);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1 cmp_on = 1;
        @(posedge clk); #1 rst_n = 1;

        // R1 reset state
        rd(A_SEC, 0, "R1 sec");   rd(A_HOUR, 0, "R1 hour");
        rd(A_DOW, 1, "R1 dow");   rd(A_DOM, 1, "R1 dom");
        rd(A_MON, 1, "R1 mon");   rd(A_YEAR, 0, "R1 year");
        rd(A_AHOUR, 0, "R1 alarm hour");
        rd(A_CTRL, 'h82, "R1 ctrl"); rd(A_STAT, 0, "R1 status");

        // R6 control readback masks undefined bits
        wr(A_CTRL, 'hFF); rd(A_CTRL, 'h86, "R6 ctrl mask");
        rd(7, 0, "R6 unmapped");

        // R2 binary seconds wrap
        wr(A_CTRL, 'h86); set_t('h05, 'h10, 'h3B); tick1();
        rd(A_SEC, 0, "R2 bin sec wrap"); rd(A_MIN, 'h11, "R2 bin min carry");
        // R3 binary 24-hour wrap
        set_t('h17, 'h3B, 'h3B); tick1(); rd(A_HOUR, 0, "R3 bin hour wrap");

        // R3/R5 BCD 24-hour, Feb 28 non-leap, weekday 7
        wr(A_CTRL, 'h82); wr(A_DOW, 7); wr(A_DOM, 'h28); wr(A_MON, 'h02); wr(A_YEAR, 'h23);
        set_t('h23, 'h59, 'h59); tick1();
        rd(A_HOUR, 0, "R3 bcd midnight"); rd(A_DOW, 1, "R5 dow wrap");
        rd(A_DOM, 1, "R5 feb end"); rd(A_MON, 3, "R5 month step");
        // R5 leap year
        wr(A_DOM, 'h28); wr(A_MON, 'h02); wr(A_YEAR, 'h24);
        set_t('h23, 'h59, 'h59); tick1(); rd(A_DOM, 'h29, "R5 leap day");
        set_t('h23, 'h59, 'h59); tick1(); rd(A_MON, 3, "R5 leap month");
        // R5 year end
        wr(A_DOM, 'h31); wr(A_MON, 'h12); wr(A_YEAR, 'h99);
        set_t('h23, 'h59, 'h59); tick1();
        rd(A_YEAR, 0, "R5 year wrap"); rd(A_MON, 1, "R5 dec wrap");
        // R5 30-day month
        wr(A_DOM, 'h30); wr(A_MON, 'h04);
        set_t('h23, 'h59, 'h59); tick1(); rd(A_MON, 5, "R5 april end");

        // R4 12-hour BCD meridian changes
        wr(A_CTRL, 'h80); wr(A_DOM, 'h05); wr(A_DOW, 3);
        set_t('h11, 'h59, 'h59); tick1(); rd(A_HOUR, 'h92, "R4 11am to 12pm");
        rd(A_DOM, 5, "R4 no day at noon");
        set_t('h92, 'h59, 'h59); tick1(); rd(A_HOUR, 'h81, "R4 12pm to 1pm");
        set_t('h91, 'h59, 'h59); tick1(); rd(A_HOUR, 'h12, "R4 11pm to 12am");
        rd(A_DOM, 6, "R4 day at midnight"); rd(A_DOW, 4, "R4 dow at midnight");
        set_t('h12, 'h59, 'h59); tick1(); rd(A_HOUR, 'h01, "R4 12am to 1am");
        // R4 12-hour binary
        wr(A_CTRL, 'h84); set_t('h8B, 'h3B, 'h3B); tick1(); rd(A_HOUR, 'h0C, "R4 bin 11pm");

        // R7 disabled updates
        wr(A_CTRL, 'h02); set_t('h04, 'h05, 'h06); tick1();
        rd(A_SEC, 6, "R7 sec held"); rd(A_STAT, 0, "R7 status idle");

        // R8 status timing and write-protect
        wr(A_CTRL, 'h82);
        @(posedge clk); #1 tick_1hz = 1;
        @(posedge clk); #1 tick_1hz = 0; addr = 4'(A_STAT);
        @(negedge clk); chk(int'(rdata), 'h80, "R8 uip set");
        @(negedge clk); chk(int'(rdata), 0, "R8 uip clear");
        rd(A_SEC, 7, "R8 advanced");
        wr(A_STAT, 'hFF); rd(A_STAT, 0, "R8 status write ignored");

        // R10 seconds bit 7
        wr(A_SEC, 'hD5); rd(A_SEC, 'h55, "R10 sec bit7");

        // R11 write collides with commit
        set_t('h10, 'h00, 'h59);
        @(posedge clk); #1 tick_1hz = 1;
        @(posedge clk); #1 tick_1hz = 0; wr_en = 1; addr = 4'(A_SEC); wdata = 'h40;
        @(posedge clk); #1 wr_en = 0;
        rd(A_SEC, 'h40, "R11 write wins"); rd(A_MIN, 'h01, "R11 others advance");

        // R9 alarm match and mismatch
        set_t('h10, 'h20, 'h30);
        wr(A_ASEC, 'h31); wr(A_AMIN, 'h20); wr(A_AHOUR, 'h10);
        n_alarm = 0;
        tick1(); chk(n_alarm, 1, "R9 match pulse");
        tick1(); chk(n_alarm, 1, "R9 past match");
        wr(A_ASEC, 'h33); wr(A_AHOUR, 'h11);
        tick1(); chk(n_alarm, 1, "R9 hour mismatch");

        repeat (3) @(posedge clk);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout exp completion");
            summary();
            $finish;
        end
    end

endmodule